// File: doc/BRIEF.md
# Mode-Dependent Memory Access Pacer

This block sits between the strobe that a processor uses to read or write video memory and the memory port of a video display controller. The controller can lose or corrupt an access that comes too soon after the previous one. The block stalls each new access until a minimum number of processor clock cycles has passed since the last accepted access. It chooses that spacing again for every access from the current settings:

- the controller generation (first or second);
- a 4-bit display mode code;
- whether the display is enabled;
- whether sprites are enabled;
- an opt-in aggressive-timing flag.

The block also holds off an access when a background command is running on the controller and the access targets the range of memory regions that the command works on. Accesses to any other region go ahead at the normal pace. When the first-generation controller is set to a mode it lacks, the block flags a configuration error and falls back to its most conservative spacing.

A request is held on `reqValid` until the cycle in which `memGo` is high. That pulse is the hand-off to the memory port. The spacing starts at the edge where `memGo` is high.

Top module: `mem_access_pacer`

## Requirements
- R1: After reset, `reqReady` is 1 and `stall` is 0, so the first request is accepted (`memGo` = 1) in its first cycle.
- R2: When an access is accepted at clock edge E with spacing N, the next access is accepted no earlier than edge E+N. With `reqValid` held and no region conflict, it is accepted exactly at E+N. The spacing N is never below 12.
- R3: Mode codes are 0 = 40-column text, 1–3 = tile graphic/multicolor, 4 = 80-column text, 5 = tile graphic, 6–9 = bitmap graphic. For the first generation (`ctrlGen` = 0) with the display on: mode 0 gives N = 12 and modes 1–3 give N = 29.
- R4: For the first generation with the display off, every valid mode (0–3) gives N = 12.
- R5: For the second generation (`ctrlGen` = 1) with display and sprites both on: text modes 0 and 4 give N = 20, and modes 1–3 and 5–9 give N = 15.
- R6: For the second generation with the display off: bitmap modes 6–9 give N = 12, tile modes 1–3 and 5 keep 15, and text modes keep 20.
- R7: For the second generation with the display on and sprites off: bitmap modes give N = 14 only when `fastTiming` = 1, and 15 otherwise. Tile and text modes are not affected.
- R8: `cfgError` is 1 whenever `ctrlGen` = 0 with a mode code of 4–15, or `ctrlGen` = 1 with a mode code of 10–15. An access accepted while it is 1 gets N = 29.
- R9: The region is `reqAddr >> REGION_SHIFT`. While `cmdBusy` = 1 and the region lies within [`cmdRegionLo`, `cmdRegionHi`] inclusive, `reqReady` is 0 and `stall` equals `reqValid`. A region outside that range is not held.
- R10: The spacing is taken from the settings at the accepting edge. Changing settings during a countdown does not alter that countdown, and the new settings apply to the next accepted access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access pending, held until `memGo` |
| reqAddr | input | ADDR_W | Memory address of the pending access |
| ctrlGen | input | 1 | Controller generation: 0 first, 1 second |
| modeCode | input | 4 | Display mode code (see R3) |
| dispEn | input | 1 | Display enabled |
| sprEn | input | 1 | Sprites enabled |
| fastTiming | input | 1 | Permit the relaxed bitmap spacing of R7 |
| cmdBusy | input | 1 | Background command running |
| cmdRegionLo | input | ADDR_W-REGION_SHIFT | First region the command touches |
| cmdRegionHi | input | ADDR_W-REGION_SHIFT | Last region the command touches |
| reqReady | output | 1 | Spacing elapsed and no region conflict |
| memGo | output | 1 | Access accepted this cycle |
| stall | output | 1 | Pending access blocked by a command conflict |
| cfgError | output | 1 | Mode not valid for the selected generation |

## Verification
The bench builds the block with `ADDR_W` = 14 and `REGION_SHIFT` = 10. This gives sixteen 1 KiB regions, so a command range can be placed with free regions both below and above it. That makes it possible to probe the inclusive lower and upper bounds and the regions just outside them. Every spacing value in the selection table (12, 14, 15, 20 and 29) is reached through the default counter width. Each is measured as the cycle distance between back-to-back acceptances.

// File: rtl/pacer_pkg.sv
package pacer_pkg;

  // Spacing values in processor cycles
  localparam int GAP_FLOOR     = 12;  // fastest the processor can issue
  localparam int GAP_G1_GFX    = 29;  // first generation, display on, graphic modes
  localparam int GAP_G2_TEXT   = 20;
  localparam int GAP_G2_GFX    = 15;
  localparam int GAP_G2_BMP_NS = 14;  // bitmap, sprites off, aggressive timing
  localparam int GAP_SAFE      = 29;  // fallback on configuration error
  localparam int GAP_W         = $clog2(GAP_SAFE + 1);

  typedef enum logic [3:0] {
    MODE_TXT40 = 4'd0,
    MODE_TILE1 = 4'd1,
    MODE_TILE2 = 4'd2,
    MODE_MULTI = 4'd3,
    MODE_TXT80 = 4'd4,
    MODE_TILE3 = 4'd5,
    MODE_BMP4  = 4'd6,
    MODE_BMP5  = 4'd7,
    MODE_BMP6  = 4'd8,
    MODE_BMP7  = 4'd9
  } modeCode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;  // access accepted: reload the spacing counter
    logic tick;  // count down one cycle
  } pacerStrobe_t;

endpackage

// File: rtl/pacer_interval_sel.sv
module pacer_interval_sel
  import pacer_pkg::*;
(
  input  logic             ctrlGen,
  input  logic [3:0]       modeCode,
  input  logic             dispEn,
  input  logic             sprEn,
  input  logic             fastTiming,
  output logic [GAP_W-1:0] gapSel,
  output logic             cfgError
);

  logic [GAP_W-1:0] rawGap;
  logic             isText;
  logic             isBitmap;
  logic             validG1;
  logic             validG2;

  always_comb begin
    isText   = (modeCode == MODE_TXT40) || (modeCode == MODE_TXT80);
    isBitmap = (modeCode >= MODE_BMP4) && (modeCode <= MODE_BMP7);
    validG1  = (modeCode <= MODE_MULTI);
    validG2  = (modeCode <= MODE_BMP7);
    cfgError = ctrlGen ? !validG2 : !validG1;
  end

  always_comb begin
    rawGap = GAP_W'(GAP_SAFE);
    if (cfgError) begin
      rawGap = GAP_W'(GAP_SAFE);
    end else if (!ctrlGen) begin
      // first generation: blanking removes every constraint
      if (!dispEn || modeCode == MODE_TXT40) rawGap = '0;
      else                                   rawGap = GAP_W'(GAP_G1_GFX);
    end else if (isText) begin
      rawGap = GAP_W'(GAP_G2_TEXT);
    end else if (!isBitmap) begin
      rawGap = GAP_W'(GAP_G2_GFX);      // tile modes ignore blanking
    end else if (!dispEn) begin
      rawGap = '0;
    end else if (!sprEn && fastTiming) begin
      rawGap = GAP_W'(GAP_G2_BMP_NS);
    end else begin
      rawGap = GAP_W'(GAP_G2_GFX);
    end
  end

  // anything under the processor's own minimum costs no extra wait
  assign gapSel = (rawGap < GAP_W'(GAP_FLOOR)) ? GAP_W'(GAP_FLOOR) : rawGap;

endmodule

// File: rtl/pacer_dpath.sv
module pacer_dpath
  import pacer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  pacerStrobe_t     strobe,
  input  logic [GAP_W-1:0] gapSel,
  output logic             cntZero
);

  logic [GAP_W-1:0] count;

  always_ff @(posedge clk) begin
    if (!rstN)            count <= '0;
    else if (strobe.load) count <= gapSel - 1'b1;
    else if (strobe.tick) count <= count - 1'b1;
  end

  assign cntZero = (count == '0);

  // R2
  load_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> cntZero);

  // R2
  gap_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (count >= GAP_W'(GAP_FLOOR - 1)));

  // R10
  steady_countdown_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cntZero && !strobe.load) |=> (count == $past(count) - 1'b1));

endmodule

// File: rtl/pacer_ctrl.sv
module pacer_ctrl
  import pacer_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int REGION_SHIFT = 11
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           reqValid,
  input  logic [ADDR_W-1:0]              reqAddr,
  input  logic                           cmdBusy,
  input  logic [ADDR_W-REGION_SHIFT-1:0] cmdRegionLo,
  input  logic [ADDR_W-REGION_SHIFT-1:0] cmdRegionHi,
  input  logic                           cntZero,
  output logic                           reqReady,
  output logic                           memGo,
  output logic                           stall,
  output pacerStrobe_t                   strobe
);

  localparam int REG_W = ADDR_W - REGION_SHIFT;

  logic [REG_W-1:0] region;
  logic             conflict;

  generate
    if (REGION_SHIFT == 0) begin : g_fullAddr
      assign region = reqAddr;
    end else begin : g_upperAddr
      assign region = reqAddr[ADDR_W-1:REGION_SHIFT];
    end
  endgenerate

  assign conflict = cmdBusy && (region >= cmdRegionLo) && (region <= cmdRegionHi);

  assign reqReady    = cntZero && !conflict;
  assign memGo       = reqValid && reqReady;
  assign stall       = reqValid && conflict;
  assign strobe.load = memGo;
  assign strobe.tick = !cntZero;

  // R2
  busy_after_go_chk: assert property (@(posedge clk) disable iff (!rstN)
    memGo |=> !reqReady);

  // R9
  conflict_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> !memGo);

endmodule

// File: rtl/mem_access_pacer.sv
module mem_access_pacer
  import pacer_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int REGION_SHIFT = 11
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           reqValid,
  input  logic [ADDR_W-1:0]              reqAddr,
  input  logic                           ctrlGen,
  input  logic [3:0]                     modeCode,
  input  logic                           dispEn,
  input  logic                           sprEn,
  input  logic                           fastTiming,
  input  logic                           cmdBusy,
  input  logic [ADDR_W-REGION_SHIFT-1:0] cmdRegionLo,
  input  logic [ADDR_W-REGION_SHIFT-1:0] cmdRegionHi,
  output logic                           reqReady,
  output logic                           memGo,
  output logic                           stall,
  output logic                           cfgError
);

  logic [GAP_W-1:0] gapSel;
  logic             cntZero;
  pacerStrobe_t     strobe;

  pacer_interval_sel u_sel (
    .ctrlGen    (ctrlGen),
    .modeCode   (modeCode),
    .dispEn     (dispEn),
    .sprEn      (sprEn),
    .fastTiming (fastTiming),
    .gapSel     (gapSel),
    .cfgError   (cfgError)
  );

  pacer_ctrl #(.ADDR_W(ADDR_W), .REGION_SHIFT(REGION_SHIFT)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqAddr     (reqAddr),
    .cmdBusy     (cmdBusy),
    .cmdRegionLo (cmdRegionLo),
    .cmdRegionHi (cmdRegionHi),
    .cntZero     (cntZero),
    .reqReady    (reqReady),
    .memGo       (memGo),
    .stall       (stall),
    .strobe      (strobe)
  );

  pacer_dpath u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .gapSel  (gapSel),
    .cntZero (cntZero)
  );

  // R8
  cfg_err_first_gen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlGen && (modeCode > 4'd3)) |-> cfgError);

endmodule

// File: tb/sim_mem_access_pacer.sv
`timescale 1ns/1ps
module sim_mem_access_pacer;

  localparam int AW = 14;
  localparam int SH = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic ctrlGen = 1'b0;
  logic [3:0] modeCode = 4'd0;
  logic dispEn = 1'b1, sprEn = 1'b1, fastTiming = 1'b0;
  logic cmdBusy = 1'b0;
  logic [AW-SH-1:0] cmdRegionLo = '0, cmdRegionHi = '0;
  logic reqReady, memGo, stall, cfgError;

  always #2.5 clk = ~clk;

  mem_access_pacer #(.ADDR_W(AW), .REGION_SHIFT(SH)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .ctrlGen(ctrlGen), .modeCode(modeCode), .dispEn(dispEn), .sprEn(sprEn),
    .fastTiming(fastTiming), .cmdBusy(cmdBusy), .cmdRegionLo(cmdRegionLo),
    .cmdRegionHi(cmdRegionHi), .reqReady(reqReady), .memGo(memGo),
    .stall(stall), .cfgError(cfgError)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int lastGo = 0;
  bit done = 0;

  typedef struct { int gap; string req; } expItem_t;
  expItem_t sb[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: memGo seen at a falling edge means acceptance at the next rising edge
  always @(negedge clk) begin
    if (rstN && memGo && !done) begin
      if (sb.size() == 0) begin
        check(1'b0, "R2 unexpected acceptance", 1, 0);
      end else begin
        expItem_t it;
        it = sb.pop_front();
        if (it.gap >= 0) check((cyc - lastGo) == it.gap, it.req, cyc - lastGo, it.gap);
      end
      lastGo = cyc;
    end
  end

  // push the expectation, raise the request, drop it after acceptance
  task automatic issue(input int gap, input string req);
    expItem_t it;
    it.gap = gap;
    it.req = req;
    sb.push_back(it);
    reqValid = 1'b1;
    do @(negedge clk); while (!memGo);
    @(posedge clk); #1;
    reqValid = 1'b0;
  endtask

  task automatic idle();
    repeat (35) @(posedge clk);
    #1;
  endtask

  task automatic pair(input bit g, input int m, input bit d, input bit s, input bit f,
                      input int gap, input string req);
    idle();
    ctrlGen = g; modeCode = 4'(m); dispEn = d; sprEn = s; fastTiming = f;
    issue(-1, req);
    issue(gap, req);
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1
    check(reqReady == 1'b1, "R1 reqReady after reset", int'(reqReady), 1);
    check(stall == 1'b0, "R1 stall after reset", int'(stall), 0);
    @(posedge clk); #1;
    reqValid = 1'b1;
    @(negedge clk);
    check(memGo == 1'b1, "R1 first access accepted at once", int'(memGo), 1);
    sb.push_back('{-1, "R1"});
    @(posedge clk); #1;
    reqValid = 1'b0;

    // R3
    pair(0, 0, 1, 1, 0, 12, "R3 gen1 text40 display on");
    pair(0, 2, 1, 1, 0, 29, "R3 gen1 graphic2 display on");
    pair(0, 3, 1, 1, 0, 29, "R3 gen1 multicolor display on");
    // R4
    pair(0, 3, 0, 1, 0, 12, "R4 gen1 multicolor display off");
    pair(0, 1, 0, 1, 0, 12, "R4 gen1 graphic1 display off");
    // R5
    pair(1, 4, 1, 1, 0, 20, "R5 gen2 text80");
    pair(1, 1, 1, 1, 0, 15, "R5 gen2 tile");
    pair(1, 7, 1, 1, 1, 15, "R5 gen2 bitmap sprites on");
    // R6
    pair(1, 8, 0, 1, 0, 12, "R6 gen2 bitmap display off");
    pair(1, 5, 0, 1, 0, 15, "R6 gen2 tile display off");
    pair(1, 0, 0, 1, 0, 20, "R6 gen2 text display off");
    // R7
    pair(1, 9, 1, 0, 1, 14, "R7 bitmap sprites off aggressive");
    pair(1, 6, 1, 0, 0, 15, "R7 bitmap sprites off normal");
    pair(1, 2, 1, 0, 1, 15, "R7 tile sprites off aggressive");

    // R8
    idle();
    ctrlGen = 1'b0; modeCode = 4'd6; dispEn = 1'b1; sprEn = 1'b1; fastTiming = 1'b0;
    @(negedge clk);
    check(cfgError == 1'b1, "R8 gen1 bitmap flagged", int'(cfgError), 1);
    @(posedge clk); #1;
    issue(-1, "R8");
    issue(29, "R8 gen1 invalid mode spacing");
    idle();
    ctrlGen = 1'b1; modeCode = 4'd12;
    @(negedge clk);
    check(cfgError == 1'b1, "R8 gen2 code 12 flagged", int'(cfgError), 1);
    @(posedge clk); #1;
    issue(-1, "R8");
    issue(29, "R8 gen2 invalid code spacing");
    modeCode = 4'd9;
    @(negedge clk);
    check(cfgError == 1'b0, "R8 gen2 bitmap not flagged", int'(cfgError), 0);
    @(posedge clk); #1;

    // R10
    idle();
    ctrlGen = 1'b1; modeCode = 4'd0; dispEn = 1'b1; sprEn = 1'b1; fastTiming = 1'b0;
    issue(-1, "R10");
    modeCode = 4'd6; dispEn = 1'b0;
    issue(20, "R10 running countdown kept");
    issue(12, "R10 new setting on next access");

    // R9
    idle();
    ctrlGen = 1'b1; modeCode = 4'd1; dispEn = 1'b1;
    cmdBusy = 1'b1; cmdRegionLo = 4'd2; cmdRegionHi = 4'd3;
    reqAddr = 14'(2 << SH);
    reqValid = 1'b1;
    repeat (3) @(negedge clk);
    check(reqReady == 1'b0, "R9 lower bound held ready", int'(reqReady), 0);
    check(stall == 1'b1, "R9 lower bound stall", int'(stall), 1);
    reqAddr = 14'((3 << SH) | 5);
    @(negedge clk);
    check(stall == 1'b1 && memGo == 1'b0, "R9 upper bound held", int'(memGo), 0);
    sb.push_back('{-1, "R9"});
    @(posedge clk); #1;
    cmdBusy = 1'b0;
    @(negedge clk);
    check(memGo == 1'b1, "R9 released after command ends", int'(memGo), 1);
    @(posedge clk); #1;
    reqValid = 1'b0;
    idle();
    cmdBusy = 1'b1;
    reqAddr = 14'(4 << SH);
    reqValid = 1'b1;
    sb.push_back('{-1, "R9"});
    @(negedge clk);
    check(memGo == 1'b1 && stall == 1'b0, "R9 region above range proceeds", int'(memGo), 1);
    @(posedge clk); #1;
    reqValid = 1'b0;
    idle();
    reqAddr = 14'((1 << SH) | 1023);
    reqValid = 1'b1;
    sb.push_back('{-1, "R9"});
    @(negedge clk);
    check(memGo == 1'b1 && stall == 1'b0, "R9 region below range proceeds", int'(memGo), 1);
    @(posedge clk); #1;
    reqValid = 1'b0;
    cmdBusy = 1'b0;

    idle();
    check(sb.size() == 0, "R2 all expected acceptances seen", sb.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule